// File: doc/BRIEF.md
# Per-Stream Serial Input Aligner

This block takes one serial TDM input stream and gives it a frame boundary of its own relative to the master frame pulse. A 4x oversample enable divides each bit period into four quarter-bit ticks. Three settings place channel zero of the stream: a whole-channel delay, a bit delay, and a choice of the quarter within each bit at which the line is sampled. The recovered bytes go to the switch core with their channel number and a one-cycle valid strobe.

The delay settings are read only at a frame pulse, so software can rewrite them at any time without tearing a frame. The byte output is a valid-only stream. It has no ready input because a serial line cannot be paused. The consumer must take every byte in the cycle in which `out_valid` is high; nothing is held back or repeated.

Top module: `stream_aligner`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is low and `out_byte` and `out_chan` are zero until the first byte completes.
- R2: Each frame of `NUM_CH`*32 oversample ticks yields exactly `NUM_CH` valid strobes. Each strobe is one cycle long. Channel numbers rise by one and wrap from `NUM_CH`-1 to 0.
- R3: The whole-channel delay `cfg_chan_dly` (0 to `NUM_CH`-1) moves the first bit of channel 0 to 32*`cfg_chan_dly` ticks after the frame-pulse tick.
- R4: With `cfg_pt_mode` low, the 5-bit `cfg_bit_dly` adds that many quarter-bit ticks to the offset, and each bit is sampled on its third quarter (the 3/4 point).
- R5: With `cfg_pt_mode` high, `cfg_bit_dly[4:2]` adds whole bits (4 ticks each) to the offset. `cfg_bit_dly[1:0]` picks the sample point: 00 gives 3/4, 01 gives 4/4, 10 gives 1/4 and 11 gives 2/4.
- R6: Bits are assembled MSB first. `out_byte` carries the eight bits of the channel given in `out_chan`.
- R7: The three delay inputs are captured only on a tick that carries the frame pulse. Changes between frame pulses have no effect on the current frame.
- R8: Nothing advances without `os_en`. A strobe appears only in the cycle after an `os_en` cycle. While `os_en` is low, no strobe appears and the alignment holds its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_en | input | 1 | Quarter-bit tick enable (4 per bit period) |
| fp | input | 1 | Frame pulse; when high on a tick, that tick is frame position 0 |
| sdi | input | 1 | Serial data in |
| cfg_chan_dly | input | 9 | Whole-channel delay of channel 0 |
| cfg_bit_dly | input | 5 | Quarter-bit delay, or whole bits plus sample point |
| cfg_pt_mode | input | 1 | Selects how `cfg_bit_dly` is read (R4 or R5) |
| out_valid | output | 1 | One-cycle strobe: a byte is complete |
| out_byte | output | 8 | Recovered byte, MSB first on the line |
| out_chan | output | $clog2(NUM_CH*32)-5 | Channel number of `out_byte` |

## Verification
The assertions assume three things about the inputs. The frame pulse arrives only on a tick. The channel delay presented at that pulse is below the channel count. After a delay change, the frame pulses come a full frame apart, so the channel sequence can restart cleanly at each pulse. The bench keeps to these rules. It issues the frame pulse only with tick 0 of its own frame counter and only uses delays inside the frame. It changes the delay inputs mid-frame only to show that they are ignored until the next pulse. It does not check the frame that directly follows a change.

// File: rtl/salign_pkg.sv
package salign_pkg;
  localparam int CD_W    = 9;   // whole-channel delay field
  localparam int BD_W    = 5;   // bit delay field
  localparam int BYTE_W  = 8;   // bits per channel
  localparam int Q_SH    = 2;   // log2 of ticks per bit
  localparam int CH_SH   = 5;   // log2 of ticks per channel
  localparam int OFF_W   = CD_W + CH_SH;

  typedef struct packed {
    logic [OFF_W-1:0] off;   // channel-0 offset in quarter-bit ticks
    logic [1:0]       sidx;  // quarter index sampled within each bit
  } align_t;

  function automatic align_t align_decode(logic [CD_W-1:0] cd,
                                          logic [BD_W-1:0] bd,
                                          logic            pt_mode);
    align_t a;
    logic [OFF_W-1:0] chan_part;
    logic [OFF_W-1:0] bit_part;
    chan_part = {cd, {CH_SH{1'b0}}};
    if (pt_mode) begin
      bit_part = {{(OFF_W-BD_W){1'b0}}, bd[BD_W-1:Q_SH], {Q_SH{1'b0}}};
      a.sidx   = bd[1:0] + 2'd2;   // 00->3/4, 01->4/4, 10->1/4, 11->2/4
    end else begin
      bit_part = {{(OFF_W-BD_W){1'b0}}, bd};
      a.sidx   = 2'd2;             // fixed 3/4 point
    end
    a.off = chan_part + bit_part;
    return a;
  endfunction
endpackage

// File: rtl/salign_cfg.sv
module salign_cfg
  import salign_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CD_W-1:0] cd_in,
  input  logic [BD_W-1:0] bd_in,
  input  logic            mode_in,
  output align_t          eff
);
  logic [CD_W-1:0] act_cd;
  logic [BD_W-1:0] act_bd;
  logic            act_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cd   <= '0;
      act_bd   <= '0;
      act_mode <= 1'b0;
    end else if (load) begin
      act_cd   <= cd_in;
      act_bd   <= bd_in;
      act_mode <= mode_in;
    end
  end

  // On the frame-pulse tick the new setting governs that tick already.
  always_comb begin
    if (load) eff = align_decode(cd_in, bd_in, mode_in);
    else      eff = align_decode(act_cd, act_bd, act_mode);
  end
endmodule

// File: rtl/salign_pos.sv
module salign_pos
  import salign_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int FQ    = NUM_CH * BYTE_W * 4,
  localparam int POS_W = $clog2(FQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_en,
  input  logic             fp,
  input  logic [OFF_W-1:0] off,
  output logic [POS_W-1:0] pos
);
  logic [POS_W-1:0] cnt;
  logic [POS_W-1:0] start;
  int unsigned      off_i;

  // Frame-pulse tick sits at delayed position (-off) mod frame length.
  always_comb begin
    off_i = {{(32-OFF_W){1'b0}}, off};
    if (off_i == 0) start = '0;
    else            start = POS_W'(FQ - off_i);
    pos = (os_en && fp) ? start : cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (os_en) begin
      if (pos == POS_W'(FQ - 1)) cnt <= '0;
      else                       cnt <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/salign_deser.sv
module salign_deser
  import salign_pkg::*;
#(
  parameter int POS_W = 10,
  localparam int CH_W = POS_W - CH_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_en,
  input  logic [POS_W-1:0]  pos,
  input  logic [1:0]        sidx,
  input  logic              sdi,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic [CH_W-1:0]   out_chan
);
  logic [BYTE_W-2:0] shreg;
  logic              take;
  logic              last_bit;

  assign take     = os_en && (pos[1:0] == sidx);
  assign last_bit = (pos[CH_SH-1:Q_SH] == 3'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (take) begin
        shreg <= {shreg[BYTE_W-3:0], sdi};
        if (last_bit) begin
          out_valid <= 1'b1;
          out_byte  <= {shreg, sdi};
          out_chan  <= pos[POS_W-1:CH_SH];
        end
      end
    end
  end
endmodule

// File: rtl/stream_aligner.sv
module stream_aligner
  import salign_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int FQ    = NUM_CH * BYTE_W * 4,
  localparam int POS_W = $clog2(FQ),
  localparam int CH_W  = POS_W - CH_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_en,
  input  logic              fp,
  input  logic              sdi,
  input  logic [CD_W-1:0]   cfg_chan_dly,
  input  logic [BD_W-1:0]   cfg_bit_dly,
  input  logic              cfg_pt_mode,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic [CH_W-1:0]   out_chan
);
  align_t           eff;
  logic [POS_W-1:0] pos;

  salign_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (os_en && fp),
    .cd_in   (cfg_chan_dly),
    .bd_in   (cfg_bit_dly),
    .mode_in (cfg_pt_mode),
    .eff     (eff)
  );

  salign_pos #(.NUM_CH(NUM_CH)) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .os_en (os_en),
    .fp    (fp),
    .off   (eff.off),
    .pos   (pos)
  );

  salign_deser #(.POS_W(POS_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_en     (os_en),
    .pos       (pos),
    .sidx      (eff.sidx),
    .sdi       (sdi),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_chan  (out_chan)
  );
endmodule

// File: rtl/salign_chk.sv
module salign_chk
  import salign_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int FQ    = NUM_CH * BYTE_W * 4,
  localparam int POS_W = $clog2(FQ),
  localparam int CH_W  = POS_W - CH_SH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             os_en,
  input logic             fp,
  input logic [CD_W-1:0]  cfg_chan_dly,
  input logic             out_valid,
  input logic [CH_W-1:0]  out_chan,
  input align_t           eff
);
  logic [CH_W-1:0] last_ch;
  logic [CH_W-1:0] nxt_ch;
  logic            seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ch <= '0;
      seen    <= 1'b0;
    end else begin
      if (out_valid) begin
        last_ch <= out_chan;
        seen    <= 1'b1;
      end else if (os_en && fp) begin
        seen    <= 1'b0;
      end
    end
  end

  assign nxt_ch = (last_ch == CH_W'(NUM_CH - 1)) ? '0 : last_ch + 1'b1;

  assert_chan_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen) |-> (out_chan == nxt_ch));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_delay_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (os_en && fp) |-> (cfg_chan_dly < CD_W'(NUM_CH)));

  assert_hold_between_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(os_en && fp) && $past(!(os_en && fp))) |-> ($stable(eff.off) && $stable(eff.sidx)));

  assert_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(os_en));
endmodule

bind stream_aligner salign_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .os_en        (os_en),
  .fp           (fp),
  .cfg_chan_dly (cfg_chan_dly),
  .out_valid    (out_valid),
  .out_chan     (out_chan),
  .eff          (eff)
);

// File: tb/stream_aligner_bench.sv
module stream_aligner_bench;
  localparam int NUM_CH = 32;
  localparam int FQ     = NUM_CH * 32;
  localparam int CH_W   = $clog2(FQ) - 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_en = 1'b0;
  logic fp = 1'b0;
  logic sdi = 1'b0;
  logic [8:0] cd = '0;
  logic [4:0] bd = '0;
  logic       pm = 1'b0;
  logic            out_valid;
  logic [7:0]      out_byte;
  logic [CH_W-1:0] out_chan;

  stream_aligner #(.NUM_CH(NUM_CH)) u_stream_aligner (
    .clk(clk), .rst_n(rst_n), .os_en(os_en), .fp(fp), .sdi(sdi),
    .cfg_chan_dly(cd), .cfg_bit_dly(bd), .cfg_pt_mode(pm),
    .out_valid(out_valid), .out_byte(out_byte), .out_chan(out_chan));

  always #2.5 clk = ~clk;   // 200 MHz

  int total = 0;
  int bad = 0;

  // stimulus and model state
  int q_next = 0, last_q = 0, gap = 1, gap_cnt = 0;
  int m_off = 0, m_sidx = 2, exp_ch0 = 0;
  int seen_cnt = 0, prev_ch = 0;
  bit have_prev = 0, chk_on = 0, chk_next = 0, ticked = 0;
  int change_q = -1;
  logic [8:0] nx_cd; logic [4:0] nx_bd; logic nx_pm;
  logic [7:0] seed = 8'h11;
  string tag = "R2";

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int c);
    return 8'(c * 37) ^ seed ^ 8'hA5;
  endfunction

  // Model of the required alignment, from R3, R4, R5.
  task automatic apply_model();
    if (pm) begin
      m_off = int'(cd) * 32 + (int'(bd) / 4) * 4;
      case (bd[1:0])
        2'b00: m_sidx = 2;
        2'b01: m_sidx = 3;
        2'b10: m_sidx = 0;
        default: m_sidx = 1;
      endcase
    end else begin
      m_off  = int'(cd) * 32 + int'(bd);
      m_sidx = 2;
    end
    exp_ch0 = (m_off + 28 + m_sidx) % FQ;
  endtask

  // Only the chosen quarter carries the true bit; the others carry its inverse.
  function automatic logic line_bit(int q);
    int p, c, b, qq;
    logic [7:0] v;
    p  = (q - m_off + FQ) % FQ;
    c  = p / 32;
    b  = 7 - ((p / 4) % 8);
    qq = p % 4;
    v  = pat(c);
    return v[b] ^ (qq != m_sidx);
  endfunction

  task automatic monitor();
    if (out_valid) begin
      if (chk_on) begin
        check(out_byte == pat(int'(out_chan)), {tag, " R6 byte"}, out_byte, pat(int'(out_chan)));
        if (have_prev)
          check(int'(out_chan) == (prev_ch + 1) % NUM_CH, "R2 chan order", out_chan, (prev_ch + 1) % NUM_CH);
        if (out_chan == '0)
          check(last_q == exp_ch0, {tag, " R3 ch0 tick"}, last_q, exp_ch0);
        seen_cnt++;
      end
      prev_ch   = int'(out_chan);
      have_prev = 1;
    end
  endtask

  task automatic drive_cycle();
    @(negedge clk);
    monitor();
    ticked = 0;
    if (gap_cnt == 0) begin
      automatic int q = q_next;
      if (q == 0) begin
        if (chk_on) check(seen_cnt == NUM_CH, "R2 bytes per frame", seen_cnt, NUM_CH);
        chk_on = chk_next; seen_cnt = 0; have_prev = 0;
        apply_model();
      end
      if (q == change_q) begin cd = nx_cd; bd = nx_bd; pm = nx_pm; end
      os_en = 1'b1; fp = (q == 0); sdi = line_bit(q);
      last_q = q; q_next = (q + 1) % FQ; gap_cnt = gap - 1; ticked = 1;
    end else begin
      os_en = 1'b0; fp = 1'b0; gap_cnt--;
    end
  endtask

  task automatic run_frame(bit chk);
    bit started = 0;
    chk_next = chk;
    forever begin
      drive_cycle();
      if (ticked && last_q == 0) started = 1;
      if (started && q_next == 0 && gap_cnt == 0) break;
    end
  endtask

  task automatic set_cfg(logic [8:0] c, logic [4:0] b, logic m, int g, string t);
    cd = c; bd = b; pm = m; gap = g; tag = t; seed = seed + 8'h3D;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    check(out_byte == 8'h00, "R1 byte after reset", out_byte, 0);
    check(out_chan == '0, "R1 chan after reset", out_chan, 0);
  endtask

  task automatic t_default();
    set_cfg(9'd0, 5'd0, 1'b0, 1, "R4 default");
    run_frame(0); run_frame(1);
  endtask

  task automatic t_chan_delay();
    set_cfg(9'd5, 5'd0, 1'b0, 2, "R3 chan delay 5");
    run_frame(0); run_frame(1);
  endtask

  task automatic t_frac_delay();
    set_cfg(9'd2, 5'd13, 1'b0, 3, "R4 quarter delay 13");
    run_frame(0); run_frame(1);
  endtask

  task automatic t_sample_points();
    for (int s = 0; s < 4; s++) begin
      set_cfg(9'd1, {3'd5, 2'(s)}, 1'b1, 1, $sformatf("R5 sel %0d", s));
      run_frame(0); run_frame(1);
    end
  endtask

  task automatic t_max_delay();
    set_cfg(9'(NUM_CH - 1), 5'd31, 1'b0, 1, "R3 max delay");
    run_frame(0); run_frame(1);
  endtask

  task automatic t_mid_change();
    set_cfg(9'd3, 5'd6, 1'b0, 1, "R7 held old");
    run_frame(0);
    nx_cd = 9'd9; nx_bd = 5'b01001; nx_pm = 1'b1; change_q = FQ / 2;
    run_frame(1);
    change_q = -1; tag = "R7 new applied";
    run_frame(0); run_frame(1);
  endtask

  task automatic t_idle();
    logic [CH_W-1:0] ch_hold;
    set_cfg(9'd4, 5'd2, 1'b0, 1, "R8 resume");
    run_frame(0); run_frame(1);
    @(negedge clk); monitor(); os_en = 1'b0; fp = 1'b0;
    ch_hold = out_chan;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (out_valid || out_chan != ch_hold) begin
        check(1'b0, "R8 strobe while idle", out_valid, 0);
        break;
      end
    end
    check(out_chan == ch_hold, "R8 channel held while idle", out_chan, ch_hold);
    run_frame(1);  // alignment must resume where it stopped
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "R2 watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_default();
    t_chan_delay();
    t_frac_delay();
    t_sample_points();
    t_max_delay();
    t_mid_change();
    t_idle();
    run_frame(0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule